// File: doc/BRIEF.md
# Edge-Programmed Auxiliary PWM Generator

This block drives one auxiliary pulse-width-modulated output. Time within a switching period is counted in coarse steps, one step per clock. Each coarse step is split into eight fine sub-slots. Every clock the block presents an 8-bit vector that a downstream serializer shifts out, one bit per fine sub-slot. Two 12-bit edge times, in fine units, place the rising and the falling edge of the pulse.

Each edge can be moved by a signed modulation value from a control loop. A per-edge enable turns this on, and a per-edge sign bit picks the direction. The moved edges are clamped to the current period. Two kinds of pulse are suppressed: a pulse whose edges fall inside the same coarse step, and a pulse whose falling edge comes before its rising edge.

When the channel is marked as the loop-regulated channel, a blanking output is raised for a programmable number of coarse steps, starting at the step that holds the rising edge. All settings are captured together at the start of a period. A change made in the middle of a period therefore cannot cut a pulse short.

Top module: `aux_edge_pwm`

## Requirements
- R1: A synchronous active-high reset clears the step counter to 0 and the latched settings. On the first clock after reset, `pwmSlots` is 0 and `blankOut` is 0.
- R2: With a latched period P > 0, the step counter advances by one per clock through 0..P-1 and then returns to 0. All inputs are sampled at the clock edge that ends step P-1, and the sampled values govern the next period. While the latched period is 0, sampling takes place on every clock.
- R3: `pwmSlots[k]` stands for fine time t = step*8 + k, so bit 0 is the earliest sub-slot of the step. When the pulse is emitted, bit k is 1 exactly when rise <= t < fall, where rise and fall are the effective edge times.
- R4: The pulse is suppressed, and the output stays 0 for the whole period, in two cases: when rise/8 equals fall/8, or when fall < rise.
- R5: With an edge's modulation enable at 0, the effective edge time is the programmed time, whatever the value of `modValue`.
- R6: With the enable at 1, the `modValue` input (two's complement) moves the edge. With sign 0 the effective time is edge - mod. With sign 1 it is edge + mod.
- R7: Effective edge times are clamped to the range 0..P*8-1. As a result, the last sub-slot of every period is 0 (bit 7 in step P-1).
- R8: A change to any input during a period has no effect on that period's output. It takes effect only from step 0 of the next period.
- R9: `blankOut` is 1 only when the latched `regulateSel` is 1 and the pulse is emitted. It is then 1 in the steps s with rise/8 <= s < rise/8 + `blankSteps`, and 0 in all other steps.
- R10: With a latched period of 0, `pwmSlots` and `blankOut` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one coarse step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| periodSteps | input | 9 | Period length in coarse steps |
| riseTime | input | 12 | Rising edge time in fine units |
| fallTime | input | 12 | Falling edge time in fine units |
| riseModEn | input | 1 | Let modulation move the rising edge |
| riseModSign | input | 1 | Rising edge direction (0: edge - mod, 1: edge + mod) |
| fallModEn | input | 1 | Let modulation move the falling edge |
| fallModSign | input | 1 | Falling edge direction (0: edge - mod, 1: edge + mod) |
| modValue | input | 10 | Signed modulation value from the loop |
| regulateSel | input | 1 | Marks this channel as loop-regulated (enables blanking) |
| blankSteps | input | 4 | Blanking window length in coarse steps |
| pwmSlots | output | 8 | Sub-slot vector for the current step, bit 0 first |
| blankOut | output | 1 | Current-sense blanking window |

## Verification
The bench builds the block with its default parameters: 12-bit edges, a 9-bit period, 10-bit modulation and a 4-bit blanking length. It keeps the programmed periods between 0 and 12 steps. Short periods make wraps frequent. They also mean that modulation values up to about ±100 regularly push both edges into the lower and upper clamps, and that blanking windows run into the end of the period. Inputs change at arbitrary steps within a period, so the once-per-period capture is exercised many times.

// File: rtl/aux_edge_pwm_pkg.sv
package aux_edge_pwm_pkg;
  localparam int FINE_W = 3;
  localparam int SLOTS = 1 << FINE_W;

  typedef struct packed {
    logic capture;   // settings are sampled at this clock edge
    logic holdLow;   // latched period is zero
  } ctrlStrobe_t;
endpackage

// File: rtl/aux_edge_pwm_ctrl.sv
module aux_edge_pwm_ctrl
  import aux_edge_pwm_pkg::*;
#(
  parameter int PERIOD_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] periodSteps,
  output ctrlStrobe_t         strobe,
  output logic [PERIOD_W-1:0] stepCnt,
  output logic [PERIOD_W-1:0] curPeriod
);
  logic lastStep;

  assign lastStep = (curPeriod == '0) || (stepCnt == curPeriod - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      stepCnt   <= '0;
      curPeriod <= '0;
    end else if (lastStep) begin
      stepCnt   <= '0;
      curPeriod <= periodSteps;
    end else begin
      stepCnt   <= stepCnt + 1'b1;
    end
  end

  assign strobe.capture = lastStep;
  assign strobe.holdLow = (curPeriod == '0);
endmodule

// File: rtl/aux_edge_pwm_dp.sv
module aux_edge_pwm_dp
  import aux_edge_pwm_pkg::*;
#(
  parameter int EDGE_W   = 12,
  parameter int PERIOD_W = 9,
  parameter int MOD_W    = 10,
  parameter int BLANK_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctrlStrobe_t             strobe,
  input  logic [PERIOD_W-1:0]     stepCnt,
  input  logic [PERIOD_W-1:0]     periodSteps,
  input  logic [EDGE_W-1:0]       riseTime,
  input  logic [EDGE_W-1:0]       fallTime,
  input  logic                    riseModEn,
  input  logic                    riseModSign,
  input  logic                    fallModEn,
  input  logic                    fallModSign,
  input  logic signed [MOD_W-1:0] modValue,
  input  logic                    regulateSel,
  input  logic [BLANK_W-1:0]      blankSteps,
  output logic [SLOTS-1:0]        pwmSlots,
  output logic                    blankOut
);
  localparam int SUM_W  = EDGE_W + 2;
  localparam int STEP_W = EDGE_W - FINE_W;

  logic signed [SUM_W-1:0] maxFine;
  logic signed [SUM_W-1:0] modExt;
  logic [EDGE_W-1:0]       nextRise, nextFall;
  logic                    nextOn;

  logic [EDGE_W-1:0]  actRise, actFall;
  logic               actOn, actReg;
  logic [BLANK_W-1:0] actBlank;

  assign maxFine = $signed({{(SUM_W-PERIOD_W-FINE_W){1'b0}}, periodSteps, {FINE_W{1'b0}}})
                   - SUM_W'(1);
  assign modExt  = {{(SUM_W-MOD_W){modValue[MOD_W-1]}}, modValue};

  function automatic logic [EDGE_W-1:0] placeEdge(
    input logic [EDGE_W-1:0]       progTime,
    input logic                    modEn,
    input logic                    modSign,
    input logic signed [SUM_W-1:0] shift,
    input logic signed [SUM_W-1:0] limit
  );
    logic signed [SUM_W-1:0] base, moved;
    base = $signed({{(SUM_W-EDGE_W){1'b0}}, progTime});
    if (!modEn)       moved = base;
    else if (modSign) moved = base + shift;
    else              moved = base - shift;
    if (moved < 0)          placeEdge = '0;
    else if (moved > limit) placeEdge = limit[EDGE_W-1:0];
    else                    placeEdge = moved[EDGE_W-1:0];
  endfunction

  assign nextRise = placeEdge(riseTime, riseModEn, riseModSign, modExt, maxFine);
  assign nextFall = placeEdge(fallTime, fallModEn, fallModSign, modExt, maxFine);
  assign nextOn   = (periodSteps != '0)
                 && (nextRise[EDGE_W-1:FINE_W] != nextFall[EDGE_W-1:FINE_W])
                 && (nextRise < nextFall);

  always_ff @(posedge clk) begin
    if (rst) begin
      actRise  <= '0;
      actFall  <= '0;
      actOn    <= 1'b0;
      actReg   <= 1'b0;
      actBlank <= '0;
    end else if (strobe.capture) begin
      actRise  <= nextRise;
      actFall  <= nextFall;
      actOn    <= nextOn;
      actReg   <= regulateSel;
      actBlank <= blankSteps;
    end
  end

  logic [EDGE_W-1:0] stepExt, riseStep, blankEnd;
  logic              pulseLive;

  assign pulseLive = actOn && !strobe.holdLow;
  assign stepExt   = EDGE_W'(stepCnt);
  assign riseStep  = {{FINE_W{1'b0}}, actRise[EDGE_W-1:FINE_W]};
  assign blankEnd  = riseStep + EDGE_W'(actBlank);
  assign blankOut  = pulseLive && actReg && (stepExt >= riseStep) && (stepExt < blankEnd);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [EDGE_W-1:0] fineT;
    assign fineT       = {stepExt[STEP_W-1:0], FINE_W'(k)};
    assign pwmSlots[k] = pulseLive && (fineT >= actRise) && (fineT < actFall);
  end
endmodule

// File: rtl/aux_edge_pwm.sv
module aux_edge_pwm
  import aux_edge_pwm_pkg::*;
#(
  parameter int EDGE_W   = 12,
  parameter int PERIOD_W = 9,
  parameter int MOD_W    = 10,
  parameter int BLANK_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PERIOD_W-1:0]     periodSteps,
  input  logic [EDGE_W-1:0]       riseTime,
  input  logic [EDGE_W-1:0]       fallTime,
  input  logic                    riseModEn,
  input  logic                    riseModSign,
  input  logic                    fallModEn,
  input  logic                    fallModSign,
  input  logic signed [MOD_W-1:0] modValue,
  input  logic                    regulateSel,
  input  logic [BLANK_W-1:0]      blankSteps,
  output logic [7:0]              pwmSlots,
  output logic                    blankOut
);
  ctrlStrobe_t         strobe;
  logic [PERIOD_W-1:0] stepCnt;
  logic [PERIOD_W-1:0] curPeriod;

  aux_edge_pwm_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk(clk), .rst(rst), .periodSteps(periodSteps),
    .strobe(strobe), .stepCnt(stepCnt), .curPeriod(curPeriod)
  );

  aux_edge_pwm_dp #(
    .EDGE_W(EDGE_W), .PERIOD_W(PERIOD_W), .MOD_W(MOD_W), .BLANK_W(BLANK_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .stepCnt(stepCnt),
    .periodSteps(periodSteps), .riseTime(riseTime), .fallTime(fallTime),
    .riseModEn(riseModEn), .riseModSign(riseModSign),
    .fallModEn(fallModEn), .fallModSign(fallModSign),
    .modValue(modValue), .regulateSel(regulateSel), .blankSteps(blankSteps),
    .pwmSlots(pwmSlots), .blankOut(blankOut)
  );
endmodule

// File: rtl/aux_edge_pwm_chk.sv
module aux_edge_pwm_chk #(
  parameter int PERIOD_W = 9
) (
  input logic                clk,
  input logic                rst,
  input logic [7:0]          pwmSlots,
  input logic                blankOut,
  input logic [PERIOD_W-1:0] stepCnt,
  input logic [PERIOD_W-1:0] curPeriod
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pwmSlots == 8'd0 && !blankOut && stepCnt == '0));

  a_r2_step_in_range: assert property (@(posedge clk) disable iff (rst)
    (curPeriod != '0) |-> (stepCnt < curPeriod));

  a_r2_step_advance: assert property (@(posedge clk) disable iff (rst)
    (curPeriod != '0 && stepCnt != curPeriod - 1'b1) |=>
      (stepCnt == PERIOD_W'($past(stepCnt) + 1'b1)));

  a_r7_last_slot_low: assert property (@(posedge clk) disable iff (rst)
    (curPeriod != '0 && stepCnt == curPeriod - 1'b1) |-> !pwmSlots[7]);

  a_r10_zero_period_low: assert property (@(posedge clk) disable iff (rst)
    (curPeriod == '0) |-> (pwmSlots == 8'd0 && !blankOut));

  a_r9_blank_starts_on_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(blankOut) |-> (pwmSlots != 8'd0));
endmodule

bind aux_edge_pwm aux_edge_pwm_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst(rst), .pwmSlots(pwmSlots), .blankOut(blankOut),
  .stepCnt(stepCnt), .curPeriod(curPeriod)
);

// File: tb/test_aux_edge_pwm.sv
module test_aux_edge_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [8:0]        periodSteps = '0;
  logic [11:0]       riseTime = '0, fallTime = '0;
  logic              riseModEn = 0, riseModSign = 0, fallModEn = 0, fallModSign = 0;
  logic signed [9:0] modValue = '0;
  logic              regulateSel = 0;
  logic [3:0]        blankSteps = '0;
  logic [7:0]        pwmSlots;
  logic              blankOut;

  int    errors = 0, checks = 0, cycles = 0;
  string tag = "R1";
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_edge_pwm i_aux_edge_pwm (
    .clk(clk), .rst(rst), .periodSteps(periodSteps), .riseTime(riseTime),
    .fallTime(fallTime), .riseModEn(riseModEn), .riseModSign(riseModSign),
    .fallModEn(fallModEn), .fallModSign(fallModSign), .modValue(modValue),
    .regulateSel(regulateSel), .blankSteps(blankSteps),
    .pwmSlots(pwmSlots), .blankOut(blankOut)
  );

  // Reference model built from the requirements
  int mStep = 0, mPeriod = 0, mRise = 0, mFall = 0, mBlank = 0;
  bit mOn = 0, mReg = 0;

  function automatic int effEdge(int e, bit en, bit sg, int m, int p);
    int s = e;
    if (en) s = sg ? e + m : e - m;
    if (s < 0) s = 0;
    if (s > p*8 - 1) s = p*8 - 1;
    return s;
  endfunction

  function automatic logic [7:0] expSlots();
    logic [7:0] v = '0;
    for (int k = 0; k < 8; k++) begin
      int t = mStep*8 + k;
      v[k] = mOn && mPeriod != 0 && t >= mRise && t < mFall;
    end
    return v;
  endfunction

  function automatic bit expBlank();
    int rs = mRise / 8;
    return mOn && mPeriod != 0 && mReg && mStep >= rs && mStep < rs + mBlank;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mStep <= 0; mPeriod <= 0; mRise <= 0; mFall <= 0;
      mOn <= 0; mReg <= 0; mBlank <= 0;
    end else if (mPeriod == 0 || mStep == mPeriod - 1) begin
      int p, r, f;
      p = int'(periodSteps);
      r = effEdge(int'(riseTime), riseModEn, riseModSign, int'(modValue), p);
      f = effEdge(int'(fallTime), fallModEn, fallModSign, int'(modValue), p);
      mStep <= 0; mPeriod <= p; mRise <= r; mFall <= f;
      mOn <= (p != 0) && (r/8 != f/8) && (r < f);
      mReg <= regulateSel; mBlank <= int'(blankSteps);
    end else begin
      mStep <= mStep + 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (step %0d)", req, what, act, exp, mStep);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check(tag, "pwmSlots", int'(pwmSlots), int'(expSlots()));
      check(tag, "blankOut", int'(blankOut), int'(expBlank()));
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setEdges(int p, int r, int f, bit ren, bit rsg, bit fen, bit fsg, int m);
    periodSteps = 9'(p); riseTime = 12'(r); fallTime = 12'(f);
    riseModEn = ren; riseModSign = rsg; fallModEn = fen; fallModSign = fsg;
    modValue = 10'(m);
  endtask

  initial begin
    // R1: reset held, then released
    runCycles(3);
    rst = 0;
    runCycles(1);
    check("R1", "pwmSlots after reset", int'(pwmSlots), 0);
    check("R1", "blankOut after reset", int'(blankOut), 0);

    tag = "R3"; setEdges(4, 5, 20, 0, 0, 0, 0, 0); runCycles(14);
    tag = "R4"; setEdges(4, 9, 14, 0, 0, 0, 0, 0); runCycles(10);
    tag = "R4"; setEdges(4, 20, 5, 0, 0, 0, 0, 0); runCycles(10);
    tag = "R5"; setEdges(4, 5, 20, 0, 1, 0, 0, 100); runCycles(10);
    tag = "R6"; setEdges(4, 10, 26, 1, 0, 1, 1, 3); runCycles(10);
    tag = "R6"; setEdges(4, 10, 26, 1, 1, 1, 0, 3); runCycles(10);
    tag = "R6"; setEdges(4, 10, 20, 1, 0, 0, 0, -4); runCycles(10);
    tag = "R7"; setEdges(4, 3, 20, 1, 0, 1, 1, 200); runCycles(10);
    tag = "R7"; setEdges(3, 0, 4000, 0, 0, 0, 0, 0); runCycles(10);
    tag = "R2"; setEdges(3, 2, 18, 0, 0, 0, 0, 0); runCycles(8);
    setEdges(7, 2, 50, 0, 0, 0, 0, 0); runCycles(16);
    tag = "R8"; setEdges(6, 4, 40, 0, 0, 0, 0, 0); runCycles(7);
    setEdges(6, 20, 30, 0, 0, 0, 0, 0); runCycles(2);
    setEdges(6, 1, 47, 0, 0, 0, 0, 0); runCycles(12);
    tag = "R9"; regulateSel = 1; blankSteps = 2;
    setEdges(6, 10, 40, 0, 0, 0, 0, 0); runCycles(14);
    blankSteps = 9; setEdges(6, 26, 44, 0, 0, 0, 0, 0); runCycles(14);
    blankSteps = 3; setEdges(6, 9, 13, 0, 0, 0, 0, 0); runCycles(14);
    regulateSel = 0; blankSteps = 3; setEdges(6, 10, 40, 0, 0, 0, 0, 0); runCycles(14);
    tag = "R10"; setEdges(0, 0, 30, 0, 0, 0, 0, 0); regulateSel = 1; runCycles(10);

    // Constrained random mix
    void'($urandom(32'h5eed_1234));
    tag = "R3";
    for (int i = 0; i < 400; i++) begin
      int p = int'($urandom_range(12, 0));
      setEdges(p, int'($urandom_range(p*8 + 16, 0)), int'($urandom_range(p*8 + 16, 0)),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               int'($urandom_range(200, 0)) - 100);
      regulateSel = 1'($urandom);
      blankSteps  = 4'($urandom);
      runCycles(int'($urandom_range(30, 1)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule